// File: doc/BRIEF.md
# Multi-Channel Periodic Interrupt Timer

This block generates periodic interrupt requests on eight independent channels. Two shared 8-bit prescalers divide the clock into tick streams. Each channel has a 16-bit down-counter, and a per-channel select bit ties it to one of the two tick streams. When a channel's counter passes zero it reloads and latches a time-out flag. The flag, gated by that channel's interrupt enable, drives the channel's own request line.

Software sets the block up through a byte-wide register port. The port has a single-cycle write strobe and a combinational read. Through it, software writes the prescaler and channel reload values, picks each channel's tick source, turns on counting globally and per channel, and acknowledges time-outs by writing ones to the flag register.

Top module: `periodic_irq_timer`

## Requirements
- R1: After reset, every register reads 0x00 and all eight `irq_o` bits are low.
- R2: Prescaler k (k = 0, 1) has an 8-bit reload value at address 0x06 + k. While global enable (address 0x00, bit 0) is 1, the prescaler emits one tick every reload+1 cycles. While global enable is 0, it is held at its reload value and emits no ticks.
- R3: Channel i has a 16-bit reload value. The low byte is at 0x08 + 2i and the high byte at 0x09 + 2i. A running channel sets flag bit i on the (reload+1)-th tick of its source and reloads on that same tick. Starting from a global-enable write, the flag becomes visible (reload_pre+1)*(reload_ch+1) cycles later.
- R4: Bit i of the source-select register (0x02) picks prescaler 0 when it is 0 and prescaler 1 when it is 1. A change takes effect on the cycle after the write, without waiting for a counter boundary.
- R5: `irq_o[i]` is high exactly when flag bit i and interrupt-enable bit i (register 0x04) are both 1. Writing the enable while the flag is already set raises the request on the next cycle.
- R6: In the flag register (0x05), writing 1 to a bit clears it and writing 0 leaves it unchanged.
- R7: If a channel sets its flag in the same cycle that software writes 1 to clear that flag, the flag stays set.
- R8: A channel counts only when global enable and its bit in the channel-enable register (0x01) are both 1. Otherwise the counter is held at its reload value and the channel never sets its flag.
- R9: Every register reads back the value last written to it. Address 0x05 is the exception: it reads the current flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Single-cycle write strobe |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 8 | Per-channel interrupt request |

## Verification
The assertions assume that the write strobe, address and data are never unknown, and that a write lasts a single cycle. The reload-after-tick and hold properties compare the counter with the load value of the previous cycle, so they stay valid even when software rewrites a load value while the channel runs. The bench drives every input on the falling edge and issues one write at a time. It keeps to mapped addresses and resets the block between scenarios, so every timing check starts from held counters.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned NUM_CH   = 8;
  localparam int unsigned NUM_BASE = 2;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned PRE_W    = 8;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned LD_BYTES = CNT_W / DATA_W;

  localparam int unsigned A_CTRL  = 0;
  localparam int unsigned A_CHEN  = 1;
  localparam int unsigned A_SEL   = 2;
  localparam int unsigned A_IRQEN = 4;
  localparam int unsigned A_FLAG  = 5;
  localparam int unsigned A_PRE   = 6;
  localparam int unsigned A_CHLD  = 8;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int unsigned W = pit_pkg::PRE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] load_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= load_i;
    else if (tick_o)  cnt_q <= load_i;
    else              cnt_q <= cnt_q - 1'b1;
  end

  // R2
  tick_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> cnt_q == $past(load_i));
  // R2
  pre_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_o) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/pit_channel.sv
module pit_channel #(
  parameter int unsigned W = pit_pkg::CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic [W-1:0] load_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  assign expire_o = run_i && tick_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i)            cnt_q <= load_i;
    else if (tick_i) begin
      if (cnt_q == '0)          cnt_q <= load_i;
      else                      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == $past(load_i));
  // R3
  expire_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> cnt_q == $past(load_i));
  // R3
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int unsigned N  = NUM_CH,
  parameter int unsigned NB = NUM_BASE,
  parameter int unsigned PW = PRE_W,
  parameter int unsigned CW = CNT_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  input  logic [N-1:0]         expire_i,
  output logic                 glob_en_o,
  output logic [N-1:0]         ch_en_o,
  output logic [N-1:0]         sel_o,
  output logic [N-1:0]         irq_o,
  output logic [NB-1:0][PW-1:0] pre_load_o,
  output logic [N-1:0][CW-1:0]  ch_load_o
);
  localparam int unsigned NBY = CW / DW;

  logic                  glob_en_q;
  logic [N-1:0]          ch_en_q, sel_q, irq_en_q, flags_q, clr_mask;
  logic [NB-1:0][PW-1:0] pre_q;
  logic [N-1:0][CW-1:0]  ld_q;

  assign clr_mask = (we_i && addr_i == AW'(A_FLAG)) ? wdata_i[N-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glob_en_q <= 1'b0;
      ch_en_q   <= '0;
      sel_q     <= '0;
      irq_en_q  <= '0;
      flags_q   <= '0;
      pre_q     <= '0;
      ld_q      <= '0;
    end else begin
      // hardware set wins over a same-cycle clear
      flags_q <= (flags_q & ~clr_mask) | expire_i;
      if (we_i) begin
        if (addr_i == AW'(A_CTRL))  glob_en_q <= wdata_i[0];
        if (addr_i == AW'(A_CHEN))  ch_en_q   <= wdata_i[N-1:0];
        if (addr_i == AW'(A_SEL))   sel_q     <= wdata_i[N-1:0];
        if (addr_i == AW'(A_IRQEN)) irq_en_q  <= wdata_i[N-1:0];
        for (int k = 0; k < NB; k++)
          if (addr_i == AW'(A_PRE + k)) pre_q[k] <= wdata_i[PW-1:0];
        for (int i = 0; i < N; i++)
          for (int b = 0; b < NBY; b++)
            if (addr_i == AW'(A_CHLD + i*NBY + b)) ld_q[i][b*DW +: DW] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      AW'(A_CTRL):  rdata_o = {{(DW-1){1'b0}}, glob_en_q};
      AW'(A_CHEN):  rdata_o = DW'(ch_en_q);
      AW'(A_SEL):   rdata_o = DW'(sel_q);
      AW'(A_IRQEN): rdata_o = DW'(irq_en_q);
      AW'(A_FLAG):  rdata_o = DW'(flags_q);
      default:      rdata_o = '0;
    endcase
    for (int k = 0; k < NB; k++)
      if (addr_i == AW'(A_PRE + k)) rdata_o = DW'(pre_q[k]);
    for (int i = 0; i < N; i++)
      for (int b = 0; b < NBY; b++)
        if (addr_i == AW'(A_CHLD + i*NBY + b)) rdata_o = ld_q[i][b*DW +: DW];
  end

  assign glob_en_o  = glob_en_q;
  assign ch_en_o    = ch_en_q;
  assign sel_o      = sel_q;
  assign pre_load_o = pre_q;
  assign ch_load_o  = ld_q;
  assign irq_o      = flags_q & irq_en_q;

  // R7
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|expire_i) |=> (flags_q & $past(expire_i)) == $past(expire_i));
  // R6
  flag_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (flags_q & $past(flags_q & ~clr_mask)) == $past(flags_q & ~clr_mask));
  // R5
  irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~flags_q) == '0);
endmodule

// File: rtl/periodic_irq_timer.sv
module periodic_irq_timer
  import pit_pkg::*;
#(
  parameter int unsigned N  = NUM_CH,
  parameter int unsigned NB = NUM_BASE,
  parameter int unsigned PW = PRE_W,
  parameter int unsigned CW = CNT_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic [N-1:0]  irq_o
);
  logic                  glob_en;
  logic [N-1:0]          ch_en, sel, expire;
  logic [NB-1:0]         tick;
  logic [NB-1:0][PW-1:0] pre_load;
  logic [N-1:0][CW-1:0]  ch_load;

  pit_regs #(.N(N), .NB(NB), .PW(PW), .CW(CW), .DW(DW), .AW(AW)) i_regs (
    .clk_i, .rst_ni,
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .expire_i   (expire),
    .glob_en_o  (glob_en),
    .ch_en_o    (ch_en),
    .sel_o      (sel),
    .irq_o      (irq_o),
    .pre_load_o (pre_load),
    .ch_load_o  (ch_load)
  );

  for (genvar k = 0; k < NB; k++) begin : g_pre
    pit_prescaler #(.W(PW)) i_pre (
      .clk_i, .rst_ni,
      .en_i   (glob_en),
      .load_i (pre_load[k]),
      .tick_o (tick[k])
    );
  end

  for (genvar i = 0; i < N; i++) begin : g_ch
    pit_channel #(.W(CW)) i_ch (
      .clk_i, .rst_ni,
      .run_i    (glob_en && ch_en[i]),
      .tick_i   (tick[sel[i]]),
      .load_i   (ch_load[i]),
      .expire_o (expire[i])
    );
  end

  // R8
  no_expire_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glob_en |-> expire == '0);
endmodule

// File: tb/test_periodic_irq_timer.sv
`timescale 1ns/1ps
module test_periodic_irq_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  periodic_irq_timer i_periodic_irq_timer (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    we = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    we = 1'b1; addr = 5'(a); wdata = 8'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    addr = 5'(a);
    #1;
    d = int'(rdata);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // cycles from the last write until irq_o[ch] is seen high
  task automatic measure(input int ch, input int lim, output int n);
    n = 0;
    while (!irq[ch] && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    int d;
    do_reset();
    for (int a = 0; a < 24; a++) begin
      rd(a, d);
      check("R1 reg reset", d, 0);
    end
    check("R1 irq reset", int'(irq), 0);
  endtask

  task automatic t_base0();
    int n;
    do_reset();
    wr(6, 3); wr(8, 2); wr(2, 0); wr(4, 8'h01); wr(1, 8'h01);
    wr(0, 1);
    measure(0, 100, n);
    check("R2/R3 base0 expiry cycles", n, 12);
    check("R3 only ch0 requests", int'(irq), 8'h01);
  endtask

  task automatic t_base1();
    int n, d;
    do_reset();
    wr(7, 1); wr(8'h0A, 4); wr(2, 8'h02); wr(4, 8'h02); wr(1, 8'h02);
    wr(0, 1);
    measure(1, 100, n);
    check("R4 base1 expiry cycles", n, 10);
    wr(8'h0B, 8'h12);
    rd(8'h0B, d); check("R9 ch1 load high readback", d, 8'h12);
    rd(8'h0A, d); check("R9 ch1 load low readback", d, 4);
    rd(7, d);     check("R9 base1 load readback", d, 1);
    rd(2, d);     check("R9 select readback", d, 8'h02);
  endtask

  task automatic t_switch();
    int n;
    do_reset();
    wr(6, 255); wr(7, 0); wr(8'h0C, 0); wr(4, 8'h04); wr(1, 8'h04);
    wr(0, 1);
    idle(20);
    check("R4 slow base no expiry yet", int'(irq), 0);
    wr(2, 8'h04);
    measure(2, 50, n);
    check("R4 immediate switch cycles", n, 1);
  endtask

  task automatic t_flags();
    int d;
    do_reset();
    wr(7, 0); wr(8'h0E, 0); wr(2, 8'h08); wr(1, 8'h08); wr(0, 1);
    idle(3);
    rd(5, d); check("R5 flag pending", d, 8'h08);
    check("R5 no irq while disabled", int'(irq), 0);
    wr(4, 8'h08);
    check("R5 immediate irq on enable", int'(irq), 8'h08);
    wr(1, 0);
    idle(2);
    wr(5, 8'h00);
    rd(5, d); check("R6 write 0 keeps flag", d, 8'h08);
    wr(5, 8'h08);
    rd(5, d); check("R6 write 1 clears flag", d, 0);
    check("R5 irq drops with flag", int'(irq), 0);
    wr(1, 8'h08);
    idle(2);
    wr(5, 8'h08);
    rd(5, d); check("R7 set wins over clear", d, 8'h08);
  endtask

  task automatic t_disable();
    int n, d;
    do_reset();
    wr(7, 0); wr(8'h10, 0); wr(2, 8'h10); wr(4, 8'h10); wr(0, 1);
    idle(50);
    rd(5, d); check("R8 channel off no flag", d, 0);
    wr(0, 0); wr(1, 8'h10);
    idle(50);
    rd(5, d); check("R8 global off no flag", d, 0);
    wr(0, 1);
    measure(4, 50, n);
    check("R8 runs once both enabled", n, 1);
  endtask

  initial begin
    t_reset();
    t_base0();
    t_base1();
    t_switch();
    t_flags();
    t_disable();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule